// File: doc/BRIEF.md
# Floating-Point Exception Status Register

This block is the status and control register that sits beside a floating-point datapath. It holds the current rounding mode and three views of the arithmetic exceptions. The per-operation cause bits show what the latest operation raised. The enable mask chooses which exceptions call for exception processing. The sticky flags gather every exception since software last cleared them.

The datapath gives a one-cycle pulse when an operation starts and a vector of exception events as it detects them. The register clears the cause bits at each start and records the new events. It ORs them into the flags. When an event is enabled, or when it is the error event, it sends a one-cycle trap request. Software reads and writes the register through a plain 32-bit data port. The rounding mode is also driven straight to the datapath.

Top module: `fpx_status_reg`

## Requirements
- R1: After reset the register reads 0x00000001: all cause, enable and flag bits are 0, the rounding mode is 01 (round to zero) and trap_req is 0.
- R2: Field layout. Bits 17:12 are the cause bits for E, V, Z, O, U, I, from bit 17 down. Bits 11:7 are the enable bits for V, Z, O, U, I, from bit 11 down. Bits 6:2 are the flag bits in the same V..I order. Bits 1:0 are the rounding mode. In exc_evt, bit 5 is E, bit 4 is V, bit 3 is Z, bit 2 is O, bit 1 is U and bit 0 is I.
- R3: A cycle with op_start high and no write leaves the cause bits holding exactly that cycle's exc_evt. Earlier causes are dropped.
- R4: In a cycle without op_start and without a write, exc_evt bits are ORed into the cause bits that are already held.
- R5: Each V..I event sets its flag bit. A flag bit stays at 1 across later operations until a software write clears it.
- R6: An event in bit k of exc_evt (k = 0..4) whose enable bit is 1 gives trap_req = 1 in the next cycle only. Events whose enable bit is 0 give no trap.
- R7: An E event always gives trap_req in the next cycle, whatever the enables hold. It sets cause bit 17 and touches no flag.
- R8: When sw_we is high, bits 17:0 take sw_wdata[17:0] at the next edge. In that cycle the write wins over op_start and exc_evt: those inputs change nothing and raise no trap.
- R9: Bits 31:18 always read 0, and writes to them are ignored.
- R10: round_mode outputs bits 1:0 (00 nearest, 01 toward zero). The reserved codes 10 and 11 are stored and output as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | One-cycle pulse as a floating-point operation begins |
| exc_evt | input | 6 | Exception events from the datapath (E,V,Z,O,U,I) |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current register contents |
| trap_req | output | 1 | One-cycle request for exception processing |
| round_mode | output | 2 | Current rounding mode |

## Verification
The assertions check several rules on every cycle. Flags never drop without a write. A write lands exactly as written, and the upper bits stay zero. An operation start leaves the cause bits holding only that cycle's events. Every trap pulse comes from an enabled event or an error event one cycle earlier, and every such event produces one. The bench scenarios are needed to show things the assertions cannot: causes building up within one operation, a reserved rounding code coming out on the port, and a disabled event staying silent while its flag still sets.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    // maskable exceptions: V Z O U I ; error E exists only as a cause
    localparam int NUM_EXC   = 5;
    localparam int CAUSE_W   = NUM_EXC + 1;
    localparam int RM_W      = 2;
    localparam int FLAG_LSB  = RM_W;
    localparam int EN_LSB    = FLAG_LSB + NUM_EXC;
    localparam int CAUSE_LSB = EN_LSB + NUM_EXC;
    localparam int REG_W     = CAUSE_LSB + CAUSE_W;
    localparam logic [RM_W-1:0] RM_RESET = 2'b01;

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic [NUM_EXC-1:0] enable;
        logic [NUM_EXC-1:0] flag;
        logic [RM_W-1:0]    rmode;
        logic               trap;
    } fpx_state_t;
endpackage

// File: rtl/fpx_cause_next.sv
module fpx_cause_next #(
    parameter int WIDTH = 6
) (
    input  logic             op_start,
    input  logic [WIDTH-1:0] evt,
    input  logic [WIDTH-1:0] cause_q,
    output logic [WIDTH-1:0] cause_nx
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // a new operation drops the old cause; this cycle's event is kept
        assign cause_nx[i] = evt[i] | (cause_q[i] & ~op_start);
    end
endmodule

// File: rtl/fpx_flag_next.sv
module fpx_flag_next #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] evt,
    input  logic [WIDTH-1:0] flag_q,
    output logic [WIDTH-1:0] flag_nx
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign flag_nx[i] = flag_q[i] | evt[i];
    end
endmodule

// File: rtl/fpx_trap_detect.sv
module fpx_trap_detect #(
    parameter int WIDTH = 5
) (
    input  logic             err_evt,
    input  logic [WIDTH-1:0] evt,
    input  logic [WIDTH-1:0] enable,
    output logic             hit
);
    logic [WIDTH-1:0] masked;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign masked[i] = evt[i] & enable[i];
    end
    assign hit = err_evt | (|masked);
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
    import fpx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [CAUSE_W-1:0] exc_evt,
    input  logic              sw_we,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] sw_rdata,
    output logic              trap_req,
    output logic [RM_W-1:0]   round_mode
);
    localparam int PAD_W = DATA_W - REG_W;

    fpx_state_t s_d, s_q;
    logic [CAUSE_W-1:0] cause_nx;
    logic [NUM_EXC-1:0] flag_nx;
    logic               trap_hit;
    logic [PAD_W-1:0]   wdata_unused_bits;

    assign wdata_unused_bits = sw_wdata[DATA_W-1:REG_W];

    fpx_cause_next #(.WIDTH(CAUSE_W)) u_cause (
        .op_start (op_start),
        .evt      (exc_evt),
        .cause_q  (s_q.cause),
        .cause_nx (cause_nx)
    );

    fpx_flag_next #(.WIDTH(NUM_EXC)) u_flag (
        .evt     (exc_evt[NUM_EXC-1:0]),
        .flag_q  (s_q.flag),
        .flag_nx (flag_nx)
    );

    fpx_trap_detect #(.WIDTH(NUM_EXC)) u_trap (
        .err_evt (exc_evt[CAUSE_W-1]),
        .evt     (exc_evt[NUM_EXC-1:0]),
        .enable  (s_q.enable),
        .hit     (trap_hit)
    );

    always_comb begin
        s_d      = s_q;
        s_d.trap = 1'b0;
        if (sw_we) begin
            s_d.cause  = sw_wdata[CAUSE_LSB +: CAUSE_W];
            s_d.enable = sw_wdata[EN_LSB +: NUM_EXC];
            s_d.flag   = sw_wdata[FLAG_LSB +: NUM_EXC];
            s_d.rmode  = sw_wdata[0 +: RM_W];
        end else begin
            s_d.cause = cause_nx;
            s_d.flag  = flag_nx;
            s_d.trap  = trap_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.rmode  <= RM_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign sw_rdata   = {{PAD_W{1'b0}}, s_q.cause, s_q.enable, s_q.flag, s_q.rmode};
    assign trap_req   = s_q.trap;
    assign round_mode = s_q.rmode;
endmodule

// File: rtl/fpx_status_chk.sv
module fpx_status_chk
    import fpx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_start,
    input logic [CAUSE_W-1:0] exc_evt,
    input logic              sw_we,
    input logic [DATA_W-1:0] sw_wdata,
    input logic [DATA_W-1:0] sw_rdata,
    input logic              trap_req,
    input logic [RM_W-1:0]   round_mode
);
    logic [NUM_EXC-1:0] flags, enables;
    logic [CAUSE_W-1:0] causes;
    assign flags   = sw_rdata[FLAG_LSB +: NUM_EXC];
    assign enables = sw_rdata[EN_LSB +: NUM_EXC];
    assign causes  = sw_rdata[CAUSE_LSB +: CAUSE_W];

    a_r3_cause_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !sw_we) |=> (causes == $past(exc_evt)));

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> ((flags & $past(flags)) == $past(flags)));

    a_r6_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(!sw_we && (exc_evt[CAUSE_W-1] ||
                                      (|(exc_evt[NUM_EXC-1:0] & enables)))));

    a_r6_trap_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && (|(exc_evt[NUM_EXC-1:0] & enables))) |=> trap_req);

    a_r7_error_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && exc_evt[CAUSE_W-1]) |=> (trap_req && causes[CAUSE_W-1]));

    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (sw_rdata[REG_W-1:0] == $past(sw_wdata[REG_W-1:0]) && !trap_req));

    a_r10_mode_out: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (round_mode == $past(sw_wdata[RM_W-1:0])));

    always @(negedge clk) begin
        if (rst_n) begin
            a_r9_upper_zero: assert (sw_rdata[DATA_W-1:REG_W] == '0);
        end
    end
endmodule

bind fpx_status_reg fpx_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_start   (op_start),
    .exc_evt    (exc_evt),
    .sw_we      (sw_we),
    .sw_wdata   (sw_wdata),
    .sw_rdata   (sw_rdata),
    .trap_req   (trap_req),
    .round_mode (round_mode)
);

// File: tb/sim_fpx_status_reg.sv
`timescale 1ns/1ps
module sim_fpx_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic [5:0]  exc_evt = '0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        trap_req;
    logic [1:0]  round_mode;

    int checks = 0;
    int fails  = 0;
    logic [17:0] mdl;           // expected register bits 17:0
    logic [34:0] exp_q[$];      // {trap, round_mode, rdata}
    string       tag_q[$];

    always #10 clk = ~clk;      // 50 MHz

    fpx_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .exc_evt(exc_evt),
        .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .trap_req(trap_req), .round_mode(round_mode)
    );

    task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got trap=%0b mode=%b rdata=%h, want trap=%0b mode=%b rdata=%h",
                     req, act[34], act[33:32], act[31:0], exp[34], exp[33:32], exp[31:0]);
        end
    endtask

    // driver: apply one cycle of stimulus and predict the result from the requirements
    task automatic step(input logic op, input logic [5:0] exc, input logic we,
                        input logic [31:0] wd, input string req);
        logic trap_exp;
        @(negedge clk);
        op_start = op; exc_evt = exc; sw_we = we; sw_wdata = wd;
        trap_exp = !we && (exc[5] || (|(exc[4:0] & mdl[11:7])));
        if (we) mdl = wd[17:0];
        else begin
            mdl[17:12] = (op ? 6'b0 : mdl[17:12]) | exc;
            mdl[6:2]   = mdl[6:2] | exc[4:0];
        end
        exp_q.push_back({trap_exp, mdl[1:0], 14'b0, mdl});
        tag_q.push_back(req);
    endtask

    // monitor: compare after each active edge
    always @(posedge clk) begin
        #5;
        if (exp_q.size() != 0) begin
            logic [34:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {trap_req, round_mode, sw_rdata}, e);
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        mdl = 18'h00001;
        repeat (3) @(posedge clk);
        #5;
        check("R1 reset", {trap_req, round_mode, sw_rdata}, {1'b0, 2'b01, 32'h1});
        @(negedge clk) rst_n = 1'b1;
        step(0, 6'h00, 0, 0, "R1 idle");
        step(1, 6'h01, 0, 0, "R2 inexact cause+flag");
        step(1, 6'h00, 0, 0, "R3 op clears cause, R5 flag kept");
        step(0, 6'h08, 0, 0, "R4 zero-divide joins");
        step(0, 6'h04, 0, 0, "R4 overflow accumulates");
        step(1, 6'h10, 0, 0, "R3 new op keeps only invalid, R6 disabled no trap");
        step(0, 6'h00, 1, 32'h0000_0F80, "R8 write enables, R5 clear flags");
        step(1, 6'h02, 0, 0, "R6 enabled underflow traps");
        step(0, 6'h00, 0, 0, "R6 single pulse");
        step(0, 6'h00, 1, 32'h0000_0400, "R8 enable only Z");
        step(1, 6'h01, 0, 0, "R6 disabled inexact silent, R5 flag set");
        step(1, 6'h20, 0, 0, "R7 error always traps");
        step(1, 6'h08, 0, 0, "R6 enabled Z traps");
        step(1, 6'h28, 1, 32'h0000_0404, "R8 write wins over hw");
        step(0, 6'h00, 1, 32'hFFFF_FFFF, "R9 upper bits ignored");
        step(0, 6'h00, 1, 32'h0000_0002, "R10 reserved mode stored");
        step(0, 6'h00, 1, 32'h0000_0000, "R10 round to nearest");
        step(0, 6'h3F, 0, 0, "R7 error plus all, R4");
        step(0, 6'h00, 0, 0, "R5 flags persist");
        @(negedge clk);
        op_start = 0; exc_evt = '0; sw_we = 0;
        repeat (2) @(posedge clk);
        #6;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule